// File: doc/BRIEF.md
# Byte-Wide Data Memory with Pointer-Redirected Access

This block is the data store of a small 8-bit controller core. One address space holds three things. At the bottom are a handful of special-function registers at fixed addresses. Above them is a reserved band that always reads as zero. Above that is general-purpose RAM. Each cycle the core presents one address, which is read combinationally. The core can write that location with a whole byte, or force one of its bits high or low. Every update lands on the rising clock edge.

Two of the low addresses are not storage; they are redirecting ports. An access to port 0 acts on the location whose address sits in pointer 0, and port 1 does the same through pointer 1. Bit operations through a port become a read-modify-write of the pointed-to byte. A pointer that aims at either port gives a null access: the read returns zero and every kind of update is dropped. One register holds a status byte that is sampled from outside every cycle and cannot be written by the core.

Address map (8-bit default): 0x00 port 0, 0x01 pointer 0, 0x02 port 1, 0x03 pointer 1, 0x04 status (read-only), 0x05 control (read/write), 0x06 to 0x3F reserved, 0x40 to 0x7F RAM, 0x80 and above unused.

Top module: `dmem_indirect`

## Requirements
- R1: A synchronous reset clears pointer 0 (0x01), pointer 1 (0x03), the control register (0x05) and the status register (0x04). In the cycle just after reset is released, all four read 0x00, whatever value `statusIn` holds.
- R2: Direct byte writes to 0x01, 0x03, 0x05 and to RAM 0x40 to 0x7F take effect at the clock edge. A read of any of these addresses returns the stored byte combinationally.
- R3: Reads of the reserved band 0x06 to 0x3F and of addresses 0x80 and above return 0x00, including after those addresses have been written.
- R4: Address 0x04 reads the value of `statusIn` captured at the previous clock edge. Byte writes and bit operations aimed at 0x04 have no effect.
- R5: A read or write of port 0 (0x00) acts on the address held in pointer 0, and port 1 (0x02) acts through pointer 1. The pointer keeps its value during the access.
- R6: When the selected pointer holds 0x00 or 0x02, a port read returns 0x00 and a port write or bit operation changes no location.
- R7: `bitSet` forces bit `bitIdx` (0 = LSB) of the target byte to 1 and `bitClr` forces it to 0, with the other seven bits unchanged. Through a port, the pointed-to byte is modified.
- R8: When several update strobes are high in the same cycle, `wrEn` wins over `bitSet`, and `bitSet` wins over `bitClr`.
- R9: A pointer aimed at 0x04 reads the status byte through its port and drops updates. A pointer aimed at an unused address reads 0x00. A pointer aimed at the other pointer's address reads and writes that pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Access address |
| wrData | input | 8 | Byte to write when `wrEn` is high |
| wrEn | input | 1 | Whole-byte write strobe |
| bitSet | input | 1 | Single-bit set strobe |
| bitClr | input | 1 | Single-bit clear strobe |
| bitIdx | input | 3 | Bit selected by `bitSet` or `bitClr` |
| statusIn | input | 8 | Value sampled into the read-only status register |
| rdData | output | 8 | Combinational read of the resolved location |

## Verification
The bench builds the block with the default parameters: 8-bit addresses, RAM base 0x40, 64 RAM bytes. With these values the first and last RAM bytes, the first reserved byte, the top of the reserved band and the unused range 0x80 to 0xFF can all be reached directly. Pointer values can also be aimed at every class of target: a port, the other pointer, the status register, RAM and unused space. This lets the null rule, the read-only rule and the redirection to a pointer each be checked through a port.

// File: rtl/dm_pkg.sv
package dm_pkg;
  localparam int DATA_W = 8;
  localparam int BIT_W  = $clog2(DATA_W);

  // Fixed special-function addresses; the ports and pointers are decoded as pairs
  localparam logic [7:0] A_PORT0 = 8'h00;
  localparam logic [7:0] A_PTR0  = 8'h01;
  localparam logic [7:0] A_PORT1 = 8'h02;
  localparam logic [7:0] A_PTR1  = 8'h03;
  localparam logic [7:0] A_STAT  = 8'h04;
  localparam logic [7:0] A_CTRL  = 8'h05;
  localparam logic [7:0] A_RSV   = 8'h06;

  typedef enum logic [2:0] {
    SRC_ZERO,
    SRC_PTR0,
    SRC_PTR1,
    SRC_STAT,
    SRC_CTRL,
    SRC_RAM
  } rdSrc_e;

  typedef struct packed {
    logic              wrPtr0;
    logic              wrPtr1;
    logic              wrCtrl;
    logic              wrRam;
    logic [DATA_W-1:0] wrVal;
  } dmStrobe_t;
endpackage

// File: rtl/dm_ctrl.sv
module dm_ctrl
  import dm_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int RAM_BASE  = 64,
  parameter int RAM_DEPTH = 64,
  localparam int RAM_AW   = $clog2(RAM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEn,
  input  logic              bitSet,
  input  logic              bitClr,
  input  logic [BIT_W-1:0]  bitIdx,
  input  logic [DATA_W-1:0] ptr0,
  input  logic [DATA_W-1:0] ptr1,
  input  logic [DATA_W-1:0] curVal,
  output rdSrc_e            rdSrc,
  output logic [RAM_AW-1:0] ramIdx,
  output dmStrobe_t         strb
);
  localparam logic [ADDR_W-1:0] P0     = ADDR_W'(A_PORT0);
  localparam logic [ADDR_W-1:0] P1     = ADDR_W'(A_PORT1);
  localparam logic [ADDR_W-1:0] Q0     = ADDR_W'(A_PTR0);
  localparam logic [ADDR_W-1:0] Q1     = ADDR_W'(A_PTR1);
  localparam logic [ADDR_W-1:0] ST     = ADDR_W'(A_STAT);
  localparam logic [ADDR_W-1:0] CT     = ADDR_W'(A_CTRL);
  localparam logic [ADDR_W-1:0] RAM_LO = ADDR_W'(RAM_BASE);
  localparam logic [ADDR_W-1:0] RAM_HI = ADDR_W'(RAM_BASE + RAM_DEPTH - 1);

  logic              isPort0, isPort1, viaPort, nullHit;
  logic [ADDR_W-1:0] effAddr;
  logic              writable, anyOp;
  logic [DATA_W-1:0] bitMask, newVal;

  // Redirect the port addresses through their pointers
  always_comb begin
    isPort0 = (addr == P0);
    isPort1 = (addr == P1);
    viaPort = isPort0 | isPort1;
    if (isPort0)      effAddr = ADDR_W'(ptr0);
    else if (isPort1) effAddr = ADDR_W'(ptr1);
    else              effAddr = addr;
    nullHit = viaPort && ((effAddr == P0) || (effAddr == P1));
  end

  // Classify the resolved address
  always_comb begin
    rdSrc = SRC_ZERO;
    if (!nullHit) begin
      if (effAddr == Q0)      rdSrc = SRC_PTR0;
      else if (effAddr == Q1) rdSrc = SRC_PTR1;
      else if (effAddr == ST) rdSrc = SRC_STAT;
      else if (effAddr == CT) rdSrc = SRC_CTRL;
      else if (effAddr >= RAM_LO && effAddr <= RAM_HI) rdSrc = SRC_RAM;
    end
    ramIdx = RAM_AW'(effAddr - RAM_LO);
  end

  // Update value: whole byte first, then set, then clear
  always_comb begin
    bitMask = DATA_W'(1) << bitIdx;
    anyOp   = wrEn | bitSet | bitClr;
    if (wrEn)        newVal = wrData;
    else if (bitSet) newVal = curVal | bitMask;
    else             newVal = curVal & ~bitMask;
    writable = (rdSrc == SRC_PTR0) || (rdSrc == SRC_PTR1) ||
               (rdSrc == SRC_CTRL) || (rdSrc == SRC_RAM);
    strb.wrPtr0 = anyOp && (rdSrc == SRC_PTR0);
    strb.wrPtr1 = anyOp && (rdSrc == SRC_PTR1);
    strb.wrCtrl = anyOp && (rdSrc == SRC_CTRL);
    strb.wrRam  = anyOp && (rdSrc == SRC_RAM);
    strb.wrVal  = writable ? newVal : '0;
  end

  // R6
  null_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    nullHit |-> !(strb.wrPtr0 || strb.wrPtr1 || strb.wrCtrl || strb.wrRam));

  // R2
  single_target_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.wrPtr0, strb.wrPtr1, strb.wrCtrl, strb.wrRam}));
endmodule

// File: rtl/dm_datapath.sv
module dm_datapath
  import dm_pkg::*;
#(
  parameter int RAM_DEPTH = 64,
  localparam int RAM_AW   = $clog2(RAM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  dmStrobe_t         strb,
  input  rdSrc_e            rdSrc,
  input  logic [RAM_AW-1:0] ramIdx,
  input  logic [DATA_W-1:0] statusIn,
  output logic [DATA_W-1:0] ptr0,
  output logic [DATA_W-1:0] ptr1,
  output logic [DATA_W-1:0] rdVal
);
  logic [DATA_W-1:0] ctrlReg, statReg;
  logic [DATA_W-1:0] mem [RAM_DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr0    <= '0;
      ptr1    <= '0;
      ctrlReg <= '0;
      statReg <= '0;
    end else begin
      statReg <= statusIn;
      if (strb.wrPtr0) ptr0    <= strb.wrVal;
      if (strb.wrPtr1) ptr1    <= strb.wrVal;
      if (strb.wrCtrl) ctrlReg <= strb.wrVal;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.wrRam) mem[ramIdx] <= strb.wrVal;
  end

  always_comb begin
    unique case (rdSrc)
      SRC_PTR0: rdVal = ptr0;
      SRC_PTR1: rdVal = ptr1;
      SRC_STAT: rdVal = statReg;
      SRC_CTRL: rdVal = ctrlReg;
      SRC_RAM:  rdVal = mem[ramIdx];
      default:  rdVal = '0;
    endcase
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (ptr0 == '0) && (ptr1 == '0) && (ctrlReg == '0) && (statReg == '0));
endmodule

// File: rtl/dmem_indirect.sv
module dmem_indirect
  import dm_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int RAM_BASE  = 64,
  parameter int RAM_DEPTH = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEn,
  input  logic              bitSet,
  input  logic              bitClr,
  input  logic [BIT_W-1:0]  bitIdx,
  input  logic [DATA_W-1:0] statusIn,
  output logic [DATA_W-1:0] rdData
);
  localparam int RAM_AW = $clog2(RAM_DEPTH);
  localparam logic [ADDR_W-1:0] RAM_LO = ADDR_W'(RAM_BASE);
  localparam logic [ADDR_W-1:0] RAM_HI = ADDR_W'(RAM_BASE + RAM_DEPTH - 1);
  localparam logic [ADDR_W-1:0] RSV_LO = ADDR_W'(A_RSV);

  dmStrobe_t         strb;
  rdSrc_e            rdSrc;
  logic [RAM_AW-1:0] ramIdx;
  logic [DATA_W-1:0] ptr0, ptr1, rdVal;

  dm_ctrl #(
    .ADDR_W   (ADDR_W),
    .RAM_BASE (RAM_BASE),
    .RAM_DEPTH(RAM_DEPTH)
  ) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .addr  (addr),
    .wrData(wrData),
    .wrEn  (wrEn),
    .bitSet(bitSet),
    .bitClr(bitClr),
    .bitIdx(bitIdx),
    .ptr0  (ptr0),
    .ptr1  (ptr1),
    .curVal(rdVal),
    .rdSrc (rdSrc),
    .ramIdx(ramIdx),
    .strb  (strb)
  );

  dm_datapath #(
    .RAM_DEPTH(RAM_DEPTH)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .rdSrc   (rdSrc),
    .ramIdx  (ramIdx),
    .statusIn(statusIn),
    .ptr0    (ptr0),
    .ptr1    (ptr1),
    .rdVal   (rdVal)
  );

  assign rdData = rdVal;

  // R3
  reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ((addr >= RSV_LO && addr < RAM_LO) || addr > RAM_HI) |-> rdData == '0);

  // R6
  null_read_chk: assert property (@(posedge clk) disable iff (rst)
    (addr == ADDR_W'(A_PORT0) &&
     (ptr0 == DATA_W'(A_PORT0) || ptr0 == DATA_W'(A_PORT1))) |-> rdData == '0);

  // R4
  status_sample_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && addr == ADDR_W'(A_STAT)) |-> rdData == $past(statusIn));

  // R7
  bit_set_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && addr == ADDR_W'(A_CTRL) &&
     $past(bitSet && !wrEn && addr == ADDR_W'(A_CTRL))) |-> rdData[$past(bitIdx)]);

  // R8
  write_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && addr == ADDR_W'(A_CTRL) &&
     $past(wrEn && addr == ADDR_W'(A_CTRL))) |-> rdData == $past(wrData));
endmodule

// File: tb/dmem_indirect_tb.sv
module dmem_indirect_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] addr = '0;
  logic [7:0] wrData = '0;
  logic       wrEn = 1'b0;
  logic       bitSet = 1'b0;
  logic       bitClr = 1'b0;
  logic [2:0] bitIdx = '0;
  logic [7:0] statusIn = '0;
  logic [7:0] rdData;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  dmem_indirect u_dut (
    .clk(clk), .rst(rst), .addr(addr), .wrData(wrData), .wrEn(wrEn),
    .bitSet(bitSet), .bitClr(bitClr), .bitIdx(bitIdx),
    .statusIn(statusIn), .rdData(rdData)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(input logic [7:0] a, input logic [7:0] d, input logic we,
                       input logic bs, input logic bc, input logic [2:0] idx);
    @(negedge clk);
    addr = a; wrData = d; wrEn = we; bitSet = bs; bitClr = bc; bitIdx = idx;
    @(negedge clk);
    wrEn = 1'b0; bitSet = 1'b0; bitClr = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    drive(a, d, 1'b1, 1'b0, 1'b0, 3'd0);
  endtask

  task automatic rdChk(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    addr = a;
    #1;
    chk(tag, rdData, exp);
  endtask

  task automatic testReset();
    addr = 8'h04;
    statusIn = 8'h5A;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 status after reset", rdData, 8'h00);
    rdChk(8'h01, 8'h00, "R1 pointer0 after reset");
    rdChk(8'h03, 8'h00, "R1 pointer1 after reset");
    rdChk(8'h05, 8'h00, "R1 control after reset");
  endtask

  task automatic testDirect();
    wr(8'h05, 8'hA5);
    rdChk(8'h05, 8'hA5, "R2 control write");
    wr(8'h40, 8'h11);
    wr(8'h7F, 8'h22);
    rdChk(8'h40, 8'h11, "R2 ram low edge");
    rdChk(8'h7F, 8'h22, "R2 ram high edge");
    wr(8'h01, 8'h45);
    rdChk(8'h01, 8'h45, "R2 pointer0 write");
  endtask

  task automatic testReserved();
    wr(8'h06, 8'hFF);
    rdChk(8'h06, 8'h00, "R3 reserved low");
    wr(8'h3F, 8'hFF);
    rdChk(8'h3F, 8'h00, "R3 reserved high");
    wr(8'h80, 8'hFF);
    rdChk(8'h80, 8'h00, "R3 unused 0x80");
    rdChk(8'hFF, 8'h00, "R3 unused 0xFF");
  endtask

  task automatic testStatus();
    @(negedge clk);
    statusIn = 8'h3C;
    rdChk(8'h04, 8'h3C, "R4 status sample");
    wr(8'h04, 8'h00);
    rdChk(8'h04, 8'h3C, "R4 status write ignored");
    drive(8'h04, 8'h00, 1'b0, 1'b0, 1'b1, 3'd2);
    rdChk(8'h04, 8'h3C, "R4 status bit clear ignored");
  endtask

  task automatic testIndirect();
    wr(8'h01, 8'h41);
    wr(8'h00, 8'h77);
    rdChk(8'h41, 8'h77, "R5 port0 write lands");
    rdChk(8'h00, 8'h77, "R5 port0 read");
    rdChk(8'h01, 8'h41, "R5 pointer0 kept");
    wr(8'h03, 8'h05);
    wr(8'h02, 8'h5A);
    rdChk(8'h05, 8'h5A, "R5 port1 write lands");
  endtask

  task automatic testNull();
    wr(8'h01, 8'h00);
    rdChk(8'h00, 8'h00, "R6 pointer0 at port0 read");
    wr(8'h00, 8'hEE);
    rdChk(8'h01, 8'h00, "R6 null write pointer0 kept");
    wr(8'h01, 8'h02);
    rdChk(8'h00, 8'h00, "R6 pointer0 at port1 read");
    wr(8'h03, 8'h02);
    wr(8'h02, 8'h33);
    drive(8'h02, 8'h00, 1'b0, 1'b1, 1'b0, 3'd0);
    rdChk(8'h03, 8'h02, "R6 null write pointer1 kept");
    rdChk(8'h05, 8'h5A, "R6 null write control kept");
  endtask

  task automatic testBits();
    wr(8'h05, 8'h00);
    drive(8'h05, 8'h00, 1'b0, 1'b1, 1'b0, 3'd7);
    rdChk(8'h05, 8'h80, "R7 set bit7");
    drive(8'h05, 8'h00, 1'b0, 1'b1, 1'b0, 3'd0);
    rdChk(8'h05, 8'h81, "R7 set bit0");
    drive(8'h05, 8'h00, 1'b0, 1'b0, 1'b1, 3'd7);
    rdChk(8'h05, 8'h01, "R7 clear bit7");
    wr(8'h01, 8'h42);
    wr(8'h42, 8'hF0);
    drive(8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 3'd4);
    rdChk(8'h42, 8'hE0, "R7 clear through port0");
  endtask

  task automatic testPriority();
    drive(8'h05, 8'h10, 1'b1, 1'b1, 1'b0, 3'd0);
    rdChk(8'h05, 8'h10, "R8 write beats set");
    drive(8'h05, 8'h00, 1'b0, 1'b1, 1'b1, 3'd3);
    rdChk(8'h05, 8'h18, "R8 set beats clear");
  endtask

  task automatic testTargets();
    wr(8'h03, 8'h04);
    rdChk(8'h02, 8'h3C, "R9 port1 to status read");
    wr(8'h02, 8'h00);
    rdChk(8'h04, 8'h3C, "R9 port1 to status write dropped");
    wr(8'h03, 8'h90);
    rdChk(8'h02, 8'h00, "R9 port1 to unused");
    wr(8'h03, 8'h01);
    wr(8'h02, 8'h43);
    rdChk(8'h01, 8'h43, "R9 port1 writes pointer0");
  endtask

  initial begin
    testReset();
    testDirect();
    testReserved();
    testStatus();
    testIndirect();
    testNull();
    testBits();
    testPriority();
    testTargets();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule